// File: doc/BRIEF.md
# CAN Nominal Bit Timing Unit

This block generates the nominal bit timing for a CAN protocol controller. It divides the module clock into time quanta with a prescaler of up to ten bits. It then walks every bit through three segments in order: one synchronisation quantum, a first phase segment and a second phase segment. The block produces three single-cycle strobes. A quantum tick marks the last clock of every quantum. A bit-start strobe marks the end of the synchronisation quantum. A sample strobe marks the end of the first phase, which is where the receive path samples the bus level.

Timing comes from a 15-bit configuration word and a 4-bit prescaler extension word. Both are loaded through a simple write port. A write lands only while the controller's init bit and its configuration-change-enable bit are both set. Any other write is dropped. While init is high, the counters are frozen and no strobes are produced. When init is cleared, the bit sequence starts fresh at a synchronisation quantum.

The sequencer is a four-state machine:
- IDLE is held while init is high.
- IDLE moves to SYNC on the first cycle with init low.
- SYNC moves to PHASE1 on a quantum tick.
- PHASE1 moves to PHASE2 on the tick that ends its last quantum.
- PHASE2 moves to SYNC on the tick that ends its last quantum.
- Every state returns to IDLE whenever init is high.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, `bt_reg` reads 0x2301 and `ext_reg` reads 0.
- R2: A write with `wr_en` high updates a register only when `cfg_change_en` and `init` are both 1. `wr_sel`=0 selects the configuration word, taken from `wr_data[14:0]`. `wr_sel`=1 selects the extension word, taken from `wr_data[3:0]`. Every other write leaves both registers unchanged.
- R3: The configuration word has the following fields: prescaler base in bits [5:0], resync jump width in bits [7:6], phase-1 length in bits [11:8] and phase-2 length in bits [14:12]. `bt_reg[15]` always reads 0.
- R4: The divider D is {ext_reg, prescaler base}, a value from 0 to 1023. `tq_tick` is a one-cycle pulse on every (D+1)-th clock, so a quantum lasts 1 to 1024 clocks.
- R5: One bit lasts 1 + (phase-1 field + 1) + (phase-2 field + 1) quanta, which allows up to 25 quanta and includes the 8 to 25 range. `bit_start` pulses together with the tick that ends the synchronisation quantum.
- R6: `sample_pt` pulses together with the tick that ends the last phase-1 quantum. It never coincides with `bit_start`.
- R7: While `init` is high, the unit produces no strobes. After `init` falls, the first clock with the state machine in SYNC is quantum clock 0, and the first tick comes D clocks later.
- R8: The reset configuration gives 8 quanta of 2 clocks each, so a bit lasts 16 clocks. This is 500 kbit/s from an 8 MHz clock.
- R9: The jump-width field is stored and read back but has no effect on the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = configuration word, 1 = prescaler extension |
| wr_data | input | 15 | Write data |
| cfg_change_en | input | 1 | Configuration-change-enable bit from the control register |
| init | input | 1 | Init bit from the control register |
| tq_tick | output | 1 | Last clock of each time quantum |
| bit_start | output | 1 | End of the synchronisation quantum |
| sample_pt | output | 1 | End of phase 1 (sample point) |
| bt_reg | output | 16 | Configuration word read-back |
| ext_reg | output | 4 | Prescaler extension read-back |

## Verification
The bench goes after the following corner cases:
- **Write protection.** It tries writes with only one of the two unlock bits set. A missing qualifier would let the configuration change.
- **Divider extremes.** It exercises a divider of 0, where a tick fires on every clock, and a divider of 1023, which uses the extension bits. An off-by-one counter, or one that drops the extension, would stretch or shrink every quantum.
- **Shortest and longest bits.** It covers the 3-quantum bit and the 25-quantum bit. Segment compares that are off by one would misplace `bit_start` and `sample_pt` there.
- **Restart after init.** It releases init and checks the first tick and the first SYNC placement. It also raises init again to confirm the outputs stay quiet. A sequencer that resumes mid-bit would fail these checks.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int BRP_W = 6;
    localparam int EXT_W = 4;
    localparam int DIV_W = BRP_W + EXT_W;
    localparam int SJW_W = 2;
    localparam int TS1_W = 4;
    localparam int TS2_W = 3;
    localparam int CFG_W = BRP_W + SJW_W + TS1_W + TS2_W;
    localparam int SEG_W = TS1_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PH1,
        ST_PH2
    } bt_state_e;

    typedef struct packed {
        logic [TS2_W-1:0] tseg2;
        logic [TS1_W-1:0] tseg1;
        logic [SJW_W-1:0] sjw;
        logic [BRP_W-1:0] brp;
    } bt_cfg_t;
endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs
    import can_bt_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_CFG = 15'h2301,
    parameter logic [EXT_W-1:0] RST_EXT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             cfg_change_en,
    input  logic             init,
    output bt_cfg_t          cfg_q,
    output logic [EXT_W-1:0] ext_q
);
    logic unlocked;
    assign unlocked = cfg_change_en && init;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= bt_cfg_t'(RST_CFG);
            ext_q <= RST_EXT;
        end else if (wr_en && unlocked) begin
            if (!wr_sel) cfg_q <= bt_cfg_t'(wr_data);
            else         ext_q <= wr_data[EXT_W-1:0];
        end
    end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             tick,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    output logic             run,
    output logic             bit_start,
    output logic             sample_pt
);
    bt_state_e        state, state_n;
    logic [SEG_W-1:0] seg, seg_n;
    logic             ph1_last, ph2_last;

    assign ph1_last = (seg == tseg1);
    assign ph2_last = (seg == SEG_W'(tseg2));

    always_comb begin
        state_n = state;
        seg_n   = seg;
        if (init) begin
            state_n = ST_IDLE;
            seg_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_SYNC;
                    seg_n   = '0;
                end
                ST_SYNC: if (tick) begin
                    state_n = ST_PH1;
                    seg_n   = '0;
                end
                ST_PH1: if (tick) begin
                    if (ph1_last) begin
                        state_n = ST_PH2;
                        seg_n   = '0;
                    end else begin
                        seg_n = seg + 1'b1;
                    end
                end
                ST_PH2: if (tick) begin
                    if (ph2_last) begin
                        state_n = ST_SYNC;
                        seg_n   = '0;
                    end else begin
                        seg_n = seg + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    seg_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            seg   <= '0;
        end else begin
            state <= state_n;
            seg   <= seg_n;
        end
    end

    always_comb begin
        run       = (state != ST_IDLE);
        bit_start = tick && (state == ST_SYNC);
        sample_pt = tick && (state == ST_PH1) && ph1_last;
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_CFG = 15'h2301,
    parameter logic [EXT_W-1:0] RST_EXT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [14:0]      wr_data,
    input  logic             cfg_change_en,
    input  logic             init,
    output logic             tq_tick,
    output logic             bit_start,
    output logic             sample_pt,
    output logic [15:0]      bt_reg,
    output logic [EXT_W-1:0] ext_reg
);
    bt_cfg_t          cfg;
    logic [EXT_W-1:0] ext;
    logic             run;

    can_bt_regs #(.RST_CFG(RST_CFG), .RST_EXT(RST_EXT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg_change_en(cfg_change_en), .init(init),
        .cfg_q(cfg), .ext_q(ext)
    );

    can_bt_prescaler u_psc (
        .clk(clk), .rst_n(rst_n), .run(run),
        .div({ext, cfg.brp}), .tick(tq_tick)
    );

    can_bt_seq u_seq (
        .clk(clk), .rst_n(rst_n), .init(init), .tick(tq_tick),
        .tseg1(cfg.tseg1), .tseg2(cfg.tseg2), .run(run),
        .bit_start(bit_start), .sample_pt(sample_pt)
    );

    assign bt_reg  = {1'b0, cfg};
    assign ext_reg = ext;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        cfg_change_en,
    input logic        init,
    input logic        tq_tick,
    input logic        bit_start,
    input logic        sample_pt,
    input logic [15:0] bt_reg,
    input logic [3:0]  ext_reg
);
    p_quiet_in_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init && $past(init)) |-> (!tq_tick && !bit_start && !sample_pt));

    p_start_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> tq_tick);

    p_sample_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> (tq_tick && !bit_start));

    p_locked_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cfg_change_en && init) |=> ($stable(bt_reg) && $stable(ext_reg)));

    p_single_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && ({ext_reg, bt_reg[5:0]} != 10'd0)) |=> !tq_tick);

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bt_reg[15]);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_change_en(cfg_change_en),
    .init(init), .tq_tick(tq_tick), .bit_start(bit_start),
    .sample_pt(sample_pt), .bt_reg(bt_reg), .ext_reg(ext_reg)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [14:0] wr_data = '0;
    logic        cfg_change_en = 1'b0;
    logic        init = 1'b1;
    logic        tq_tick, bit_start, sample_pt;
    logic [15:0] bt_reg;
    logic [3:0]  ext_reg;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    can_bit_timer u_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg_change_en(cfg_change_en), .init(init),
        .tq_tick(tq_tick), .bit_start(bit_start), .sample_pt(sample_pt),
        .bt_reg(bt_reg), .ext_reg(ext_reg)
    );

    function automatic logic [14:0] pack_cfg(int brp, int sjw, int t1, int t2);
        return {3'(t2), 4'(t1), 2'(sjw), 6'(brp)};
    endfunction

    function automatic int bit_quanta(int t1, int t2);
        return 3 + t1 + t2;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [14:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cfg(int brp, int ext, int sjw, int t1, int t2, int nbits, bit load);
        int q, n, bad;
        logic [14:0] c;
        c = pack_cfg(brp, sjw, t1, t2);
        init = 1'b1;
        if (load) begin
            cfg_change_en = 1'b1;
            wr(1'b0, c);
            wr(1'b1, 15'(ext));
            cfg_change_en = 1'b0;
            check("R3 cfg readback", 32'(bt_reg), {17'd0, c});
            check("R2 ext readback", 32'(ext_reg), 32'(ext));
        end
        q = (ext * 64 + brp) + 1;
        n = bit_quanta(t1, t2);
        @(negedge clk);
        init = 1'b0;
        @(posedge clk);
        bad = 0;
        for (int k = 0; k < nbits * n * q; k++) begin
            logic et, eb, es;
            int p;
            @(negedge clk);
            p  = (k / q) % n;
            et = (k % q) == q - 1;
            eb = et && (p == 0);
            es = et && (p == 1 + t1);
            n_chk++;
            if (tq_tick !== et || bit_start !== eb || sample_pt !== es) begin
                n_bad++;
                bad++;
                if (bad < 4)
                    $display("FAIL R4/R5/R6/R9 k=%0d actual=%b%b%b expected=%b%b%b",
                             k, tq_tick, bit_start, sample_pt, et, eb, es);
            end
        end
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R7 quiet in init", {29'd0, tq_tick, bit_start, sample_pt}, 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset cfg", 32'(bt_reg), 32'h2301);
        check("R1 reset ext", 32'(ext_reg), 32'd0);

        // R8: reset configuration, 16 clocks per bit
        run_cfg(1, 0, 0, 3, 2, 3, 1'b0);

        // R2: writes with one unlock bit missing are dropped
        init = 1'b1; cfg_change_en = 1'b0;
        wr(1'b0, 15'h7fff);
        wr(1'b1, 15'h000f);
        check("R2 no cce cfg", 32'(bt_reg), 32'h2301);
        check("R2 no cce ext", 32'(ext_reg), 32'd0);
        init = 1'b0; cfg_change_en = 1'b1;
        wr(1'b0, 15'h1234);
        wr(1'b1, 15'h0005);
        check("R2 no init cfg", 32'(bt_reg), 32'h2301);
        check("R2 no init ext", 32'(ext_reg), 32'd0);
        init = 1'b1;
        wr(1'b0, 15'h7fff);
        check("R3 bit15 zero", 32'(bt_reg[15]), 32'd0);
        check("R2 unlocked write", 32'(bt_reg), 32'h7fff);
        cfg_change_en = 1'b0;

        // R4/R5 extremes
        run_cfg(0, 0, 3, 0, 0, 3, 1'b1);
        run_cfg(0, 0, 1, 15, 7, 2, 1'b1);
        run_cfg(63, 15, 2, 3, 2, 1, 1'b1);

        // constrained random, R9 via random jump width
        for (int i = 0; i < 20; i++) begin
            int b, s, a, z;
            b = $urandom % 64;
            s = $urandom % 4;
            a = $urandom % 16;
            z = $urandom % 8;
            run_cfg(b, 0, s, a, z, 2, 1'b1);
        end
        run_cfg(5, 1, 0, 4, 3, 1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule